// File: doc/BRIEF.md
# Address-Space-Tagged Associative Translation Buffer

This block is a fully associative translation buffer of page-table entries. Each slot holds a virtual page tag, an 8-bit address-space number, a global flag, a physical page number, a per-mode read-enable mask, a per-mode write-enable mask, and fault-on-read and fault-on-write flags. A lookup is combinational. It takes a virtual address and the current address-space number, and in the same cycle it returns hit, the slot index, the page number and the permission bits. The virtual page number is the address shifted right by `PAGE_SHIFT`, which is 13 by default for 8 KB pages.

New entries always go into the slot named by a round-robin victim pointer. The pointer and the entry it names can be read at the victim port. The pointer can also be stepped on its own, so a refill agent can inspect a slot before it replaces it. Three maintenance operations exist: wipe every slot, drop only the entries that are not global, and drop the entries of one page that the given address-space number can see. The insert port is valid/ready. `ins_ready` is low in any cycle where a flush request is raised. An insert offered in that cycle is not taken and must be held by the producer. No other back-pressure exists. Lookups are never stalled.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vaddr >> PAGE_SHIFT` and whose global flag is set or whose stored number equals `lk_asn`. On a hit, `lk_ppn`, `lk_global`, the permission masks and the fault flags of that slot appear in the same cycle. On a miss, all of these outputs are zero.
- R2: An accepted insert (`ins_valid && ins_ready`) writes the slot at `vic_ptr` with tag `ins_vaddr >> PAGE_SHIFT`, sets it valid and replaces any valid content there. The pointer advances by one on the next edge.
- R3: The victim pointer wraps from `ENTRIES-1` to 0. `vic_adv` steps it by one when no insert is accepted. An insert and `vic_adv` raised together step it only once.
- R4: `fl_all` clears every field of every slot to zero and sets the pointer to 0.
- R5: `fl_nonglobal` invalidates every slot whose global flag is clear. Global slots and the pointer stay as they are.
- R6: `fl_page` invalidates every slot that a lookup of `fl_vaddr`/`fl_asn` would hit under the R1 rule. Other slots and the pointer stay as they are.
- R7: Priority is `fl_all` over `fl_nonglobal` over `fl_page` over insert/advance, and one operation is applied per cycle. `ins_ready` is low while any flush input is high. An insert offered then has no effect.
- R8: `vic_valid`, `vic_vpn` and `vic_ppn` show the slot at `vic_ptr` combinationally.
- R9: When several slots hit, `lk_idx` and the returned data are those of the lowest-index hitting slot.
- R10: After synchronous reset (`rst` high), all slots are zero and invalid and `vic_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Hitting slot index (0 on miss) |
| lk_ppn | output | PPN_W | Physical page number of hit |
| lk_global | output | 1 | Global flag of hit |
| lk_rd_en | output | NMODES | Per-mode read enables of hit |
| lk_wr_en | output | NMODES | Per-mode write enables of hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of hit |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_vaddr | input | VA_W | Virtual address of new entry |
| ins_asn | input | ASN_W | Address-space number of new entry |
| ins_global | input | 1 | Global flag of new entry |
| ins_ppn | input | PPN_W | Physical page number of new entry |
| ins_rd_en | input | NMODES | Read enables of new entry |
| ins_wr_en | input | NMODES | Write enables of new entry |
| ins_fault_rd | input | 1 | Fault-on-read of new entry |
| ins_fault_wr | input | 1 | Fault-on-write of new entry |
| fl_all | input | 1 | Wipe all slots |
| fl_nonglobal | input | 1 | Invalidate non-global slots |
| fl_page | input | 1 | Invalidate one page |
| fl_vaddr | input | VA_W | Address for page flush |
| fl_asn | input | ASN_W | Address-space number for page flush |
| vic_adv | input | 1 | Step victim pointer |
| vic_ptr | output | IDX_W | Victim pointer |
| vic_valid | output | 1 | Valid flag of victim slot |
| vic_vpn | output | VPN_W | Tag of victim slot |
| vic_ppn | output | PPN_W | Physical page number of victim slot |

## Verification
Several lookup patterns are used. The same page is looked up under a matching number, a foreign number, and against a global entry, which separates the tag compare from the number compare and from the global override. A page that is present twice under one number shows whether the lowest slot wins. Inserts run past the last slot, and some are mixed with lone and simultaneous pointer steps, to show wrap and single stepping. Each flush kind is run over a mix of global, matching and foreign entries, and inserts are offered during flushes. Together these show which slots each flush kills and that a flush blocks the insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WIPE,
    OP_DROP_LOCAL,
    OP_DROP_PAGE,
    OP_INSERT,
    OP_STEP
  } tlb_op_e;
endpackage

// File: rtl/tlb_op_arb.sv
module tlb_op_arb
  import tlb_pkg::*;
(
  input  logic    fl_all,
  input  logic    fl_nonglobal,
  input  logic    fl_page,
  input  logic    ins_valid,
  input  logic    vic_adv,
  output logic    ins_ready,
  output tlb_op_e op
);
  always_comb begin
    ins_ready = !(fl_all || fl_nonglobal || fl_page);
    if (fl_all)                      op = OP_WIPE;
    else if (fl_nonglobal)           op = OP_DROP_LOCAL;
    else if (fl_page)                op = OP_DROP_PAGE;
    else if (ins_valid)              op = OP_INSERT;
    else if (vic_adv)                op = OP_STEP;
    else                             op = OP_IDLE;
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  tlb_op_e          op,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst || op == OP_WIPE) ptr <= '0;
    else if (op == OP_INSERT || op == OP_STEP)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 30,
  parameter int ASN_W  = 8,
  parameter int PPN_W  = 28,
  parameter int NMODES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  tlb_op_e           op,
  input  logic              sel,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASN_W-1:0]  wr_asn,
  input  logic              wr_glob,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [NMODES-1:0] wr_rd,
  input  logic [NMODES-1:0] wr_wr,
  input  logic              wr_fr,
  input  logic              wr_fw,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  output logic              o_valid,
  output logic [VPN_W-1:0]  o_vpn,
  output logic [ASN_W-1:0]  o_asn,
  output logic              o_glob,
  output logic [PPN_W-1:0]  o_ppn,
  output logic [NMODES-1:0] o_rd,
  output logic [NMODES-1:0] o_wr,
  output logic              o_fr,
  output logic              o_fw,
  output logic              o_lk_match
);
  logic fl_match;

  assign o_lk_match = o_valid && (o_vpn == lk_vpn) && (o_glob || o_asn == lk_asn);
  assign fl_match   = o_valid && (o_vpn == fl_vpn) && (o_glob || o_asn == fl_asn);

  always_ff @(posedge clk) begin
    if (rst || op == OP_WIPE) begin
      o_valid <= 1'b0;
      o_vpn   <= '0;
      o_asn   <= '0;
      o_glob  <= 1'b0;
      o_ppn   <= '0;
      o_rd    <= '0;
      o_wr    <= '0;
      o_fr    <= 1'b0;
      o_fw    <= 1'b0;
    end else begin
      case (op)
        OP_DROP_LOCAL: if (!o_glob) o_valid <= 1'b0;
        OP_DROP_PAGE:  if (fl_match) o_valid <= 1'b0;
        OP_INSERT: if (sel) begin
          o_valid <= 1'b1;
          o_vpn   <= wr_vpn;
          o_asn   <= wr_asn;
          o_glob  <= wr_glob;
          o_ppn   <= wr_ppn;
          o_rd    <= wr_rd;
          o_wr    <= wr_wr;
          o_fr    <= wr_fr;
          o_fw    <= wr_fw;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = 6
) (
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES    = 48,
  parameter int VA_W       = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int ASN_W      = 8,
  parameter int PPN_W      = 28,
  parameter int NMODES     = 4,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_global,
  output logic [NMODES-1:0] lk_rd_en,
  output logic [NMODES-1:0] lk_wr_en,
  output logic              lk_fault_rd,
  output logic              lk_fault_wr,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [VA_W-1:0]   ins_vaddr,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [NMODES-1:0] ins_rd_en,
  input  logic [NMODES-1:0] ins_wr_en,
  input  logic              ins_fault_rd,
  input  logic              ins_fault_wr,
  input  logic              fl_all,
  input  logic              fl_nonglobal,
  input  logic              fl_page,
  input  logic [VA_W-1:0]   fl_vaddr,
  input  logic [ASN_W-1:0]  fl_asn,
  input  logic              vic_adv,
  output logic [IDX_W-1:0]  vic_ptr,
  output logic              vic_valid,
  output logic [VPN_W-1:0]  vic_vpn,
  output logic [PPN_W-1:0]  vic_ppn
);
  tlb_op_e op;

  logic [ENTRIES-1:0] e_valid, e_glob, e_fr, e_fw, e_match;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [NMODES-1:0]  e_rd  [ENTRIES];
  logic [NMODES-1:0]  e_wr  [ENTRIES];

  logic [VPN_W-1:0] lk_vpn, fl_vpn, ins_vpn;
  assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_SHIFT];
  assign fl_vpn  = fl_vaddr[VA_W-1:PAGE_SHIFT];
  assign ins_vpn = ins_vaddr[VA_W-1:PAGE_SHIFT];

  tlb_op_arb u_arb (
    .fl_all(fl_all), .fl_nonglobal(fl_nonglobal), .fl_page(fl_page),
    .ins_valid(ins_valid), .vic_adv(vic_adv), .ins_ready(ins_ready), .op(op)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .op(op), .ptr(vic_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_entry #(.VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .NMODES(NMODES)) u_ent (
      .clk(clk), .rst(rst), .op(op), .sel(vic_ptr == IDX_W'(g)),
      .wr_vpn(ins_vpn), .wr_asn(ins_asn), .wr_glob(ins_global), .wr_ppn(ins_ppn),
      .wr_rd(ins_rd_en), .wr_wr(ins_wr_en), .wr_fr(ins_fault_rd), .wr_fw(ins_fault_wr),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .fl_vpn(fl_vpn), .fl_asn(fl_asn),
      .o_valid(e_valid[g]), .o_vpn(e_vpn[g]), .o_asn(e_asn[g]), .o_glob(e_glob[g]),
      .o_ppn(e_ppn[g]), .o_rd(e_rd[g]), .o_wr(e_wr[g]), .o_fr(e_fr[g]), .o_fw(e_fw[g]),
      .o_lk_match(e_match[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  tlb_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_first (
    .match(e_match), .any(any_hit), .idx(hit_idx)
  );

  always_comb begin
    lk_hit      = any_hit;
    lk_idx      = hit_idx;
    lk_ppn      = any_hit ? e_ppn[hit_idx] : '0;
    lk_global   = any_hit && e_glob[hit_idx];
    lk_rd_en    = any_hit ? e_rd[hit_idx] : '0;
    lk_wr_en    = any_hit ? e_wr[hit_idx] : '0;
    lk_fault_rd = any_hit && e_fr[hit_idx];
    lk_fault_wr = any_hit && e_fw[hit_idx];
    vic_valid   = e_valid[vic_ptr];
    vic_vpn     = e_vpn[vic_ptr];
    vic_ppn     = e_ppn[vic_ptr];
  end
endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int ENTRIES = 48,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_hit,
  input logic             lk_global,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             fl_all,
  input logic             fl_nonglobal,
  input logic             fl_page,
  input logic [IDX_W-1:0] vic_ptr,
  input logic             vic_valid
);
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (vic_ptr == '0 && !vic_valid && !lk_hit));

  a_r2_insert_step: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready) |=>
      vic_ptr == (($past(vic_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(vic_ptr) + 1'b1));

  a_r2_insert_valid: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && ENTRIES == 1) |=> vic_valid);

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (rst)
    vic_ptr <= IDX_W'(ENTRIES - 1));

  a_r4_wipe: assert property (@(posedge clk) disable iff (rst)
    fl_all |=> (vic_ptr == '0 && !vic_valid && !lk_hit));

  a_r5_only_global_left: assert property (@(posedge clk) disable iff (rst)
    (fl_nonglobal && !fl_all) |=> (!lk_hit || lk_global));

  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (rst)
    (fl_all || fl_nonglobal || fl_page) |-> !ins_ready);

  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!fl_all && (fl_nonglobal || fl_page)) |=> $stable(vic_ptr));
endmodule

bind asn_tlb asn_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_global(lk_global),
  .ins_valid(ins_valid), .ins_ready(ins_ready), .fl_all(fl_all),
  .fl_nonglobal(fl_nonglobal), .fl_page(fl_page), .vic_ptr(vic_ptr),
  .vic_valid(vic_valid)
);

// File: tb/test_asn_tlb.sv
module test_asn_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int VA  = 43;
  localparam int SH  = 13;
  localparam int AW  = 8;
  localparam int PW  = 28;
  localparam int MW  = 4;
  localparam int VW  = VA - SH;
  localparam int IW  = 3;

  logic clk = 0, rst = 1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [VA-1:0] lk_vaddr = '0, ins_vaddr = '0, fl_vaddr = '0;
  logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
  logic ins_valid = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
  logic [PW-1:0] ins_ppn = '0;
  logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0;
  logic fl_all = 0, fl_nonglobal = 0, fl_page = 0, vic_adv = 0;

  logic lk_hit, lk_global, lk_fault_rd, lk_fault_wr, ins_ready, vic_valid;
  logic [IW-1:0] lk_idx, vic_ptr;
  logic [PW-1:0] lk_ppn, vic_ppn;
  logic [MW-1:0] lk_rd_en, lk_wr_en;
  logic [VW-1:0] vic_vpn;

  asn_tlb #(.ENTRIES(N), .VA_W(VA), .PAGE_SHIFT(SH), .ASN_W(AW), .PPN_W(PW), .NMODES(MW)) i_asn_tlb (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_asn(lk_asn), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_global(lk_global), .lk_rd_en(lk_rd_en),
    .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vaddr(ins_vaddr), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr), .fl_all(fl_all),
    .fl_nonglobal(fl_nonglobal), .fl_page(fl_page), .fl_vaddr(fl_vaddr), .fl_asn(fl_asn),
    .vic_adv(vic_adv), .vic_ptr(vic_ptr), .vic_valid(vic_valid), .vic_vpn(vic_vpn),
    .vic_ppn(vic_ppn)
  );

  // behavioural reference
  bit      m_v [N];
  longint  m_vpn [N];
  int      m_asn [N];
  bit      m_g [N];
  longint  m_ppn [N];
  int      m_rd [N];
  int      m_wr [N];
  bit      m_fr [N];
  bit      m_fw [N];
  int      m_ptr;

  int checks = 0, fails = 0;

  function automatic bit sees(int i, longint vpn, int asn);
    return m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn);
  endfunction

  always @(posedge clk) begin
    if (rst || fl_all) begin
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_g[i] = 0; m_ppn[i] = 0;
        m_rd[i] = 0; m_wr[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
      end
      m_ptr = 0;
    end else if (fl_nonglobal) begin
      for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
    end else if (fl_page) begin
      for (int i = 0; i < N; i++)
        if (sees(i, longint'(fl_vaddr >> SH), int'(fl_asn))) m_v[i] = 0;
    end else if (ins_valid) begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = longint'(ins_vaddr >> SH); m_asn[m_ptr] = int'(ins_asn);
      m_g[m_ptr] = ins_global; m_ppn[m_ptr] = longint'(ins_ppn);
      m_rd[m_ptr] = int'(ins_rd_en); m_wr[m_ptr] = int'(ins_wr_en);
      m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
      m_ptr = (m_ptr + 1) % N;
    end else if (vic_adv) begin
      m_ptr = (m_ptr + 1) % N;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int  hit_i;
      longint lv;
      hit_i = -1;
      lv = longint'(lk_vaddr >> SH);
      for (int i = N - 1; i >= 0; i--) if (sees(i, lv, int'(lk_asn))) hit_i = i;
      chk(lk_hit == (hit_i >= 0), "R1 hit", lk_hit, hit_i >= 0);
      if (hit_i >= 0) begin
        chk(lk_idx == hit_i, "R9 lowest index", lk_idx, hit_i);
        chk(lk_ppn == m_ppn[hit_i], "R1 ppn", lk_ppn, m_ppn[hit_i]);
        chk(lk_global == m_g[hit_i] && lk_rd_en == m_rd[hit_i] && lk_wr_en == m_wr[hit_i]
            && lk_fault_rd == m_fr[hit_i] && lk_fault_wr == m_fw[hit_i],
            "R1 perms", {lk_global, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr},
            {m_g[hit_i], 4'(m_rd[hit_i]), 4'(m_wr[hit_i]), m_fr[hit_i], m_fw[hit_i]});
      end else begin
        chk(lk_ppn == 0 && !lk_global && lk_rd_en == 0, "R1 miss zero", lk_ppn, 0);
      end
      chk(vic_ptr == m_ptr, "R3 pointer", vic_ptr, m_ptr);
      chk(vic_valid == m_v[m_ptr] && vic_vpn == m_vpn[m_ptr] && vic_ppn == m_ppn[m_ptr],
          "R8 victim view", {vic_valid, vic_vpn}, {m_v[m_ptr], 30'(m_vpn[m_ptr])});
      chk(ins_ready == !(fl_all || fl_nonglobal || fl_page), "R7 ready", ins_ready,
          !(fl_all || fl_nonglobal || fl_page));
    end
  end

  function automatic logic [VA-1:0] va(longint vpn, int off);
    return {VW'(vpn), SH'(off)};
  endfunction

  task automatic step();
    @(posedge clk); #1;
    ins_valid = 0; fl_all = 0; fl_nonglobal = 0; fl_page = 0; vic_adv = 0;
  endtask

  task automatic put(longint vpn, int asn, bit g, longint ppn);
    ins_valid = 1; ins_vaddr = va(vpn, 8'h5a); ins_asn = AW'(asn); ins_global = g;
    ins_ppn = PW'(ppn); ins_rd_en = MW'(ppn); ins_wr_en = MW'(ppn >> 1);
    ins_fault_rd = ppn[0]; ins_fault_wr = ppn[1];
    step();
  endtask

  task automatic look(longint vpn, int asn);
    lk_vaddr = va(vpn, 13'h1abc); lk_asn = AW'(asn);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R10: reset state seen at the ports
    chk(vic_ptr == 0 && !vic_valid, "R10 reset", vic_ptr, 0);
    step();
    // R2 fills, mixed global / numbers
    put(64'h100, 5, 0, 28'h0aaa1);
    put(64'h200, 9, 1, 28'h0bbb2);
    put(64'h100, 7, 0, 28'h0ccc3);
    look(64'h100, 5); look(64'h100, 7); look(64'h100, 3);   // R1 asn match/foreign
    look(64'h200, 1); look(64'h300, 9);                    // R1 global / absent tag
    put(64'h100, 5, 0, 28'h0ddd6);                        // R9 duplicate
    look(64'h100, 5);
    // R7 insert offered during each flush kind is dropped
    ins_valid = 1; ins_vaddr = va(64'h777, 0); fl_page = 1; fl_vaddr = va(64'h999, 0); step();
    ins_valid = 1; vic_adv = 1; fl_nonglobal = 1; fl_all = 0; step();
    look(64'h777, 0);
    put(64'h100, 5, 0, 28'h0eee7);
    put(64'h100, 7, 0, 28'h0fff8);
    // R3 wrap and stepping
    for (int k = 0; k < 5; k++) put(64'h400 + k, k, k[0], 28'h123 + k);
    vic_adv = 1; step();
    vic_adv = 1; step();
    vic_adv = 1; ins_valid = 1; ins_vaddr = va(64'h500, 0); ins_asn = 1; step();
    for (int k = 0; k < 10; k++) begin vic_adv = 1; step(); end
    put(64'h100, 5, 0, 28'h01111);
    put(64'h100, 7, 1, 28'h02222);
    put(64'h100, 8, 0, 28'h03333);
    // R6 page flush: number 5 sees its own and global entry
    look(64'h100, 5);
    fl_page = 1; fl_vaddr = va(64'h100, 3); fl_asn = 5; step();
    look(64'h100, 5); look(64'h100, 8); look(64'h100, 7);
    // R5 local flush keeps globals
    fl_nonglobal = 1; step();
    look(64'h100, 8); look(64'h402, 2); look(64'h401, 9);
    // R4 wipe
    fl_all = 1; step();
    look(64'h401, 9);
    put(64'h600, 2, 0, 28'h4444);
    look(64'h600, 2);
    repeat (2) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule